// File: doc/BRIEF.md
# Row/Column Data Pointer RAM

This block is a small nibble-wide data memory for a 4-bit controller. It holds three rows of sixteen 4-bit words. It is addressed through a pointer that is split into two registers: a row register and a column register. The processor side can load either register on its own and read back both. It reads the nibble under the pointer combinationally and writes that nibble on a clock edge. As a side effect of the same access, it can step the column register up or down. When a step crosses the end of the column range, a one-cycle wrap flag lets an instruction sequencer raise a skip condition.

A second port is read-only. It lets a display scanner fetch any nibble by its own row and column, without touching the processor-side pointer. Only three of the four row codes hold storage. The fourth reads as zero and swallows writes.

Top module: `rdp_ram`

## Requirements
- R1: While reset is active and after it is released, `row_q` is 0, `col_q` is 0 and `wrap_o` is 0 until the first load or step.
- R2: When `row_ld` is 1 at a clock edge, `row_q` takes `row_din` after that edge. When `col_ld` is 1 at an edge, `col_q` takes `col_din`. Each register changes only through its own controls and otherwise holds its value.
- R3: `col_op` encodes the column step: 2'b01 increments `col_q`, 2'b10 decrements it, and 2'b00 and 2'b11 leave it unchanged. When `col_ld` is 1, the load wins over any step.
- R4: Incrementing from 15 gives 0, and decrementing from 0 gives 15. `wrap_o` is 1 in exactly the cycle that follows such a wrapping step and is 0 in every other cycle, including after a load.
- R5: When `wr_en` is 1 at a clock edge, `wr_data` is stored in the word at the row and column held before that edge. `rd_data` always shows, combinationally, the word at the current `row_q`/`col_q`.
- R6: A write in the same cycle as a row load, a column load or a column step uses the address from before the update. The new pointer value takes effect from the next cycle.
- R7: Row code 3 holds no storage. `rd_data` is 0 while `row_q` is 3, and a write with `row_q` equal to 3 changes no stored word.
- R8: `disp_data` is, combinationally, the word at `disp_row`/`disp_col`, or 0 when `disp_row` is 3. Driving the display address never changes `row_q`, `col_q` or `wrap_o`.
- R9: All 48 words are independent: a value written to one row/column position is read back there and leaves every other position unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| row_ld | input | 1 | Load the row register from `row_din` |
| row_din | input | ROW_W (2) | New row code |
| col_ld | input | 1 | Load the column register from `col_din` |
| col_din | input | COL_W (4) | New column value |
| col_op | input | 2 | Column step: 01 increment, 10 decrement, 00/11 hold |
| wr_en | input | 1 | Write `wr_data` at the current pointer |
| wr_data | input | DATA_W (4) | Write nibble |
| row_q | output | ROW_W (2) | Current row register |
| col_q | output | COL_W (4) | Current column register |
| rd_data | output | DATA_W (4) | Word under the pointer, 0 in row 3 |
| wrap_o | output | 1 | One-cycle pulse after a wrapping column step |
| disp_row | input | ROW_W (2) | Display port row |
| disp_col | input | COL_W (4) | Display port column |
| disp_data | output | DATA_W (4) | Word at the display address, 0 in row 3 |

## Verification
The bench builds the block with its default parameters: three populated rows, a 4-bit column and 4-bit data. With these values a full column sweep takes only sixteen steps, so both wrap directions come within a few cycles. They also leave one row code without storage, so the zero-read and ignored-write behaviour of row 3 can be exercised. The display port scans every address, including row 3, after the processor-side fills and stray writes. This shows that the cells are independent and that the pointer is not disturbed.

// File: rtl/rdp_pkg.sv
package rdp_pkg;
  typedef enum logic [1:0] {
    STEP_NONE = 2'b00,
    STEP_UP   = 2'b01,
    STEP_DOWN = 2'b10,
    STEP_RSVD = 2'b11
  } step_e;
endpackage

// File: rtl/rdp_rst_sync.sv
module rdp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign rst_core_n = chain[STAGES-1];
endmodule

// File: rtl/rdp_pointer.sv
module rdp_pointer
  import rdp_pkg::*;
#(
  parameter int ROW_W = 2,
  parameter int COL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             row_ld,
  input  logic [ROW_W-1:0] row_din,
  input  logic             col_ld,
  input  logic [COL_W-1:0] col_din,
  input  logic [1:0]       col_op,
  output logic [ROW_W-1:0] row_q,
  output logic [COL_W-1:0] col_q,
  output logic             wrap_o
);
  localparam logic [COL_W-1:0] COL_TOP = {COL_W{1'b1}};

  step_e            step;
  logic [ROW_W-1:0] row_nxt;
  logic [COL_W-1:0] col_nxt;
  logic             wrap_nxt;
  logic             row_en;
  logic             col_en;

  assign step = step_e'(col_op);

  always_comb begin
    row_en   = row_ld;
    row_nxt  = row_din;
    col_en   = 1'b0;
    col_nxt  = col_q;
    wrap_nxt = 1'b0;
    if (col_ld) begin
      col_en  = 1'b1;
      col_nxt = col_din;
    end else begin
      unique case (step)
        STEP_UP: begin
          col_en   = 1'b1;
          col_nxt  = col_q + 1'b1;
          wrap_nxt = (col_q == COL_TOP);
        end
        STEP_DOWN: begin
          col_en   = 1'b1;
          col_nxt  = col_q - 1'b1;
          wrap_nxt = (col_q == '0);
        end
        default: begin
          col_en  = 1'b0;
          col_nxt = col_q;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      row_q <= '0;
    else if (row_en) row_q <= row_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      col_q <= '0;
    else if (col_en) col_q <= col_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wrap_o <= 1'b0;
    else        wrap_o <= wrap_nxt;
  end
endmodule

// File: rtl/rdp_store.sv
module rdp_store #(
  parameter int ROWS   = 3,
  parameter int ROW_W  = 2,
  parameter int COL_W  = 4,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ROW_W-1:0]  wrow,
  input  logic [COL_W-1:0]  wcol,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ROW_W-1:0]  arow,
  input  logic [COL_W-1:0]  acol,
  output logic [DATA_W-1:0] adata,
  input  logic [ROW_W-1:0]  brow,
  input  logic [COL_W-1:0]  bcol,
  output logic [DATA_W-1:0] bdata
);
  localparam int COLS = 1 << COL_W;

  logic [ROWS-1:0][DATA_W-1:0] row_a;
  logic [ROWS-1:0][DATA_W-1:0] row_b;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic [DATA_W-1:0] words [COLS];
    logic              row_we;

    assign row_we = we && (wrow == ROW_W'(r));

    always_ff @(posedge clk) begin
      if (row_we) words[wcol] <= wdata;
    end

    assign row_a[r] = words[acol];
    assign row_b[r] = words[bcol];
  end

  always_comb begin
    adata = '0;
    bdata = '0;
    for (int r = 0; r < ROWS; r++) begin
      if (arow == ROW_W'(r)) adata = row_a[r];
      if (brow == ROW_W'(r)) bdata = row_b[r];
    end
  end
endmodule

// File: rtl/rdp_ram.sv
module rdp_ram #(
  parameter int ROWS   = 3,
  parameter int ROW_W  = 2,
  parameter int COL_W  = 4,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              row_ld,
  input  logic [ROW_W-1:0]  row_din,
  input  logic              col_ld,
  input  logic [COL_W-1:0]  col_din,
  input  logic [1:0]        col_op,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [ROW_W-1:0]  row_q,
  output logic [COL_W-1:0]  col_q,
  output logic [DATA_W-1:0] rd_data,
  output logic              wrap_o,
  input  logic [ROW_W-1:0]  disp_row,
  input  logic [COL_W-1:0]  disp_col,
  output logic [DATA_W-1:0] disp_data
);
  logic rst_core_n;

  rdp_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  rdp_pointer #(.ROW_W(ROW_W), .COL_W(COL_W)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .row_ld  (row_ld),
    .row_din (row_din),
    .col_ld  (col_ld),
    .col_din (col_din),
    .col_op  (col_op),
    .row_q   (row_q),
    .col_q   (col_q),
    .wrap_o  (wrap_o)
  );

  rdp_store #(
    .ROWS(ROWS), .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)
  ) u_mem (
    .clk   (clk),
    .we    (wr_en),
    .wrow  (row_q),
    .wcol  (col_q),
    .wdata (wr_data),
    .arow  (row_q),
    .acol  (col_q),
    .adata (rd_data),
    .brow  (disp_row),
    .bcol  (disp_col),
    .bdata (disp_data)
  );
endmodule

// File: rtl/rdp_ram_chk.sv
module rdp_ram_chk #(
  parameter int ROWS   = 3,
  parameter int ROW_W  = 2,
  parameter int COL_W  = 4,
  parameter int DATA_W = 4
) (
  input logic              clk,
  input logic              rst_core_n,
  input logic              row_ld,
  input logic [ROW_W-1:0]  row_din,
  input logic              col_ld,
  input logic [COL_W-1:0]  col_din,
  input logic [1:0]        col_op,
  input logic [ROW_W-1:0]  row_q,
  input logic [COL_W-1:0]  col_q,
  input logic [DATA_W-1:0] rd_data,
  input logic              wrap_o,
  input logic [ROW_W-1:0]  disp_row,
  input logic [DATA_W-1:0] disp_data
);
  localparam logic [COL_W-1:0] TOP = {COL_W{1'b1}};

  assert_row_load_R2: assert property (@(posedge clk) disable iff (!rst_core_n)
    row_ld |=> row_q == $past(row_din));
  assert_row_hold_R2: assert property (@(posedge clk) disable iff (!rst_core_n)
    !row_ld |=> $stable(row_q));
  assert_col_load_R3: assert property (@(posedge clk) disable iff (!rst_core_n)
    col_ld |=> col_q == $past(col_din));
  assert_col_up_R3: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!col_ld && col_op == 2'b01) |=> col_q == COL_W'($past(col_q) + 1'b1));
  assert_col_down_R3: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!col_ld && col_op == 2'b10) |=> col_q == COL_W'($past(col_q) - 1'b1));
  assert_col_idle_R3: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!col_ld && (col_op == 2'b00 || col_op == 2'b11)) |=> $stable(col_q));
  assert_wrap_set_R4: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!col_ld && ((col_op == 2'b01 && col_q == TOP) || (col_op == 2'b10 && col_q == '0)))
    |=> wrap_o);
  assert_wrap_clr_R4: assert property (@(posedge clk) disable iff (!rst_core_n)
    !(!col_ld && ((col_op == 2'b01 && col_q == TOP) || (col_op == 2'b10 && col_q == '0)))
    |=> !wrap_o);
  assert_row3_zero_R7: assert property (@(posedge clk) disable iff (!rst_core_n)
    (row_q == ROW_W'(ROWS)) |-> rd_data == '0);
  assert_disp_row3_R8: assert property (@(posedge clk) disable iff (!rst_core_n)
    (disp_row == ROW_W'(ROWS)) |-> disp_data == '0);
endmodule

bind rdp_ram rdp_ram_chk #(
  .ROWS(ROWS), .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)
) u_chk (
  .clk        (clk),
  .rst_core_n (rst_core_n),
  .row_ld     (row_ld),
  .row_din    (row_din),
  .col_ld     (col_ld),
  .col_din    (col_din),
  .col_op     (col_op),
  .row_q      (row_q),
  .col_q      (col_q),
  .rd_data    (rd_data),
  .wrap_o     (wrap_o),
  .disp_row   (disp_row),
  .disp_data  (disp_data)
);

// File: tb/sim_rdp_ram.sv
`timescale 1ns/1ps
module sim_rdp_ram;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       row_ld = 1'b0;
  logic [1:0] row_din = '0;
  logic       col_ld = 1'b0;
  logic [3:0] col_din = '0;
  logic [1:0] col_op = '0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_data = '0;
  logic [1:0] row_q;
  logic [3:0] col_q;
  logic [3:0] rd_data;
  logic       wrap_o;
  logic [1:0] disp_row = '0;
  logic [3:0] disp_col = '0;
  logic [3:0] disp_data;

  always #2.5 clk = ~clk;

  rdp_ram u0 (
    .clk(clk), .rst_n(rst_n), .row_ld(row_ld), .row_din(row_din),
    .col_ld(col_ld), .col_din(col_din), .col_op(col_op), .wr_en(wr_en),
    .wr_data(wr_data), .row_q(row_q), .col_q(col_q), .rd_data(rd_data),
    .wrap_o(wrap_o), .disp_row(disp_row), .disp_col(disp_col),
    .disp_data(disp_data)
  );

  typedef struct {
    logic [1:0]  row;
    logic [3:0]  col;
    logic        wrap;
    logic        chk_rd;
    logic [3:0]  rd;
    logic        chk_dp;
    logic [3:0]  dp;
    logic [15:0] tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [3:0] m_mem [3][16];
  bit         m_known [3][16];
  logic [1:0] m_row = '0;
  logic [3:0] m_col = '0;

  task automatic cmp(input logic [15:0] tag, input string what,
                     input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic void peek(input logic [1:0] r, input logic [3:0] c,
                               output logic ok, output logic [3:0] v);
    if (r == 2'd3) begin ok = 1; v = 4'h0; end
    else begin ok = m_known[r][c]; v = m_mem[r][c]; end
  endfunction

  task automatic drive(input logic rl, input logic [1:0] rd, input logic cl,
                       input logic [3:0] cd, input logic [1:0] op,
                       input logic we, input logic [3:0] wd,
                       input logic [1:0] dr, input logic [3:0] dc,
                       input logic [15:0] tag);
    exp_t e;
    @(negedge clk);
    row_ld = rl; row_din = rd; col_ld = cl; col_din = cd; col_op = op;
    wr_en = we; wr_data = wd; disp_row = dr; disp_col = dc;
    if (we && m_row != 2'd3) begin
      m_mem[m_row][m_col] = wd;
      m_known[m_row][m_col] = 1;
    end
    e.wrap = !cl && ((op == 2'b01 && m_col == 4'hF) || (op == 2'b10 && m_col == 4'h0));
    if (rl) m_row = rd;
    if (cl) m_col = cd;
    else if (op == 2'b01) m_col = m_col + 4'd1;
    else if (op == 2'b10) m_col = m_col - 4'd1;
    e.row = m_row; e.col = m_col; e.tag = tag;
    peek(m_row, m_col, e.chk_rd, e.rd);
    peek(dr, dc, e.chk_dp, e.dp);
    q.push_back(e);
  endtask

  task automatic idle(input logic [1:0] dr, input logic [3:0] dc, input logic [15:0] tag);
    drive(0, 2'd0, 0, 4'd0, 2'b00, 0, 4'd0, dr, dc, tag);
  endtask

  always @(posedge clk) begin
    exp_t e;
    #1;
    if (q.size() > 0) begin
      e = q.pop_front();
      cmp(e.tag, "row_q", {2'b00, row_q}, {2'b00, e.row});
      cmp(e.tag, "col_q", col_q, e.col);
      cmp(e.tag, "wrap_o", {3'b000, wrap_o}, {3'b000, e.wrap});
      if (e.chk_rd) cmp(e.tag, "rd_data", rd_data, e.rd);
      if (e.chk_dp) cmp(e.tag, "disp_data", disp_data, e.dp);
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < 3; r++)
      for (int c = 0; c < 16; c++) m_known[r][c] = 0;
    repeat (3) @(negedge clk);
    cmp("R1", "row_q in reset", {2'b00, row_q}, 4'h0);
    cmp("R1", "col_q in reset", col_q, 4'h0);
    cmp("R1", "wrap in reset", {3'b000, wrap_o}, 4'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cmp("R1", "row_q after release", {2'b00, row_q}, 4'h0);
    cmp("R1", "col_q after release", col_q, 4'h0);
    cmp("R1", "wrap after release", {3'b000, wrap_o}, 4'h0);

    // R9 R5 R4: fill every row with an increment sweep, wrapping at the end
    for (int r = 0; r < 3; r++) begin
      drive(1, 2'(r), 1, 4'd0, 2'b00, 0, 4'd0, 2'd0, 4'd0, "R2");
      for (int c = 0; c < 16; c++)
        drive(0, 2'd0, 0, 4'd0, 2'b01, 1, 4'((r * 7 + c * 3 + 1) & 15), 2'd0, 4'd0, "R5");
      idle(2'd0, 4'd0, "R4");
    end

    // R4: decrement sweep reading row 1, wrapping at 0
    drive(1, 2'd1, 1, 4'd15, 2'b00, 0, 4'd0, 2'd0, 4'd0, "R2");
    for (int c = 0; c < 16; c++)
      drive(0, 2'd0, 0, 4'd0, 2'b10, 0, 4'd0, 2'd1, 4'(c), "R4");
    idle(2'd1, 4'd3, "R4");

    // R3: reserved step code holds, load beats a step
    drive(0, 2'd0, 0, 4'd0, 2'b11, 0, 4'd0, 2'd1, 4'd3, "R3");
    drive(0, 2'd0, 1, 4'd15, 2'b01, 0, 4'd0, 2'd1, 4'd3, "R3");
    drive(0, 2'd0, 1, 4'd0, 2'b10, 0, 4'd0, 2'd1, 4'd3, "R3");
    drive(0, 2'd0, 1, 4'd7, 2'b01, 0, 4'd0, 2'd1, 4'd3, "R3");

    // R7: row 3 reads zero and ignores writes
    drive(1, 2'd3, 1, 4'd0, 2'b00, 0, 4'd0, 2'd3, 4'd0, "R7");
    for (int c = 0; c < 16; c++)
      drive(0, 2'd0, 0, 4'd0, 2'b01, 1, 4'hA, 2'd3, 4'(c), "R7");

    // R6: write together with row load, column load and step
    drive(1, 2'd0, 1, 4'd5, 2'b00, 0, 4'd0, 2'd0, 4'd5, "R6");
    drive(1, 2'd2, 0, 4'd0, 2'b00, 1, 4'h9, 2'd0, 4'd5, "R6");
    drive(0, 2'd0, 1, 4'd9, 2'b00, 1, 4'h6, 2'd2, 4'd5, "R6");
    drive(0, 2'd0, 0, 4'd0, 2'b10, 1, 4'h3, 2'd2, 4'd9, "R6");
    idle(2'd2, 4'd8, "R6");

    // R8 R9 R7: display scan of all addresses without moving the pointer
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 16; c++)
        idle(2'(r), 4'(c), "R8");

    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule